// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block serialises one byte at a time onto a single-wire smart card line. Each character is a low start bit, eight data bits sent least significant first, and a parity bit that is always present. After the parity bit the line rests high, so the card sees a guard interval before the next character may begin. The time of one bit is a whole number of base clock cycles, picked by a two-bit divider select from a set that includes 372, which is not a power of two.

The host presents a byte on a valid/ready handshake. The byte is only taken while the transmitter is idle. At that moment the parity sense, the divider select and the early-completion mode are captured from their register-style inputs. A transmit-end flag reports that the line is free again. In the normal mode this flag rises 12.5 bit times after the start edge. With early completion it rises at 11.0 bit times. Accepting the next byte clears the flag.

Top module: `sc_char_tx`

## Requirements
- R1: Coming out of reset, `tx_line` is 1, `in_ready` is 1 and `tx_done` is 1.
- R2: The bit time in clock cycles is set by `cfg_div`, as captured at acceptance: 2'b00 gives 32, 2'b01 gives 64, 2'b10 gives 372 and 2'b11 gives 256.
- R3: The line goes low on the clock edge that accepts a byte and stays low for one bit time. Data bits 0 to 7 then follow in that order, one bit time each, followed by the parity bit. From the end of the parity bit the line is 1.
- R4: With `cfg_odd` = 0 the parity bit makes the count of ones over data and parity even. With `cfg_odd` = 1 it makes that count odd.
- R5: With `cfg_early` = 0, `tx_done` rises and `in_ready` returns to 1 exactly 12.5 bit times (25 half bit times) after the accepting edge.
- R6: With `cfg_early` = 1, `tx_done` rises and `in_ready` returns to 1 exactly 11.0 bit times after the accepting edge.
- R7: `in_ready` is 0 from the accepting edge until the end point of R5 or R6. A byte offered with `in_valid` while `in_ready` is 0 is not taken and produces no frame.
- R8: Accepting a byte clears `tx_done`. Otherwise `tx_done` stays 1 while the transmitter is idle.
- R9: Changes to `cfg_div`, `cfg_odd`, `cfg_early` or `in_data` after the accepting edge do not alter the frame in progress or its end point.
- R10: `tx_line` changes only on a bit boundary of a frame or on an accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_div | input | 2 | Divider select for clocks per bit |
| cfg_early | input | 1 | Early-completion mode for the end flag |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle; a byte is taken when valid and ready are both 1 |
| tx_line | output | 1 | Serial data output, idle high |
| tx_done | output | 1 | Transmit-end flag |

## Verification
Two events can fall on neighbouring edges: the raising of the transmit-end flag and the acceptance of a byte that is already waiting. The bench provokes this by holding `in_valid` high with a second byte while the first frame is still on the line. On the edge where the first frame ends, the flag rises and ready returns. The waiting byte is taken on the very next edge, which clears the flag again. The bench judges this by requiring the flag to be seen at the exact end cycle of the first frame, and then requiring the second start bit to begin one cycle later with its full bit pattern. The bench also changes the configuration inputs and the data right after every acceptance, so a frame that leaked those inputs would show the wrong bits or end at the wrong time.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  localparam int unsigned CHAR_BITS      = 8;
  localparam int unsigned CPB_SEL0       = 32;
  localparam int unsigned CPB_SEL1       = 64;
  localparam int unsigned CPB_SEL2       = 372;
  localparam int unsigned CPB_SEL3       = 256;
  // end points counted in half bit times from the start edge
  localparam int unsigned END_HALF_NORM  = 25;
  localparam int unsigned END_HALF_EARLY = 22;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sc_half_timer.sv
// Half-bit-time counter: reloads on every half bit boundary, period captured at start.
module sc_half_timer #(
  parameter int unsigned CPB_0 = 32,
  parameter int unsigned CPB_1 = 64,
  parameter int unsigned CPB_2 = 372,
  parameter int unsigned CPB_3 = 256,
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       half_tick
);

  localparam int unsigned N_SEL = 4;

  logic [CNT_W-1:0] half_tab [N_SEL];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  generate
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
      localparam int unsigned CPB = (g == 0) ? CPB_0 :
                                    (g == 1) ? CPB_1 :
                                    (g == 2) ? CPB_2 : CPB_3;
      assign half_tab[g] = CNT_W'(CPB / 2 - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= half_tab[0];
    end else if (start) begin
      cnt_q    <= half_tab[sel];
      reload_q <= half_tab[sel];
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign half_tick = run && (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= reload_q)); // R2
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(reload_q)); // R9

endmodule

// File: rtl/sc_frame_shift.sv
// Frame shifter: start, data LSB first, parity; fills with idle ones.
module sc_frame_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              odd,
  input  logic              shift,
  output logic              line
);

  localparam int unsigned FRAME_W = DATA_W + 2;

  logic [FRAME_W-1:0] sh_q;
  logic               par;

  assign par = (^data) ^ odd;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '1;
    else if (load)  sh_q <= {par, data, 1'b0};
    else if (shift) sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
  end

  assign line = sh_q[0];

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    load |=> !line); // R3

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = CHAR_BITS,
  parameter int unsigned CPB_0      = CPB_SEL0,
  parameter int unsigned CPB_1      = CPB_SEL1,
  parameter int unsigned CPB_2      = CPB_SEL2,
  parameter int unsigned CPB_3      = CPB_SEL3,
  parameter int unsigned HALF_NORM  = END_HALF_NORM,
  parameter int unsigned HALF_EARLY = END_HALF_EARLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_odd,
  input  logic [1:0]        cfg_div,
  input  logic              cfg_early,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_line,
  output logic              tx_done
);

  localparam int unsigned MAX_CPB = max_of4(CPB_0, CPB_1, CPB_2, CPB_3);
  localparam int unsigned CNT_W   = $clog2(MAX_CPB / 2);
  localparam int unsigned HALF_W  = $clog2(HALF_NORM + 1);

  logic              busy_q;
  logic              done_q;
  logic [HALF_W-1:0] hidx_q;
  logic [HALF_W-1:0] hend_q;
  logic              accept;
  logic              half_tick;
  logic              bit_tick;
  logic              end_hit;

  assign accept   = in_valid && !busy_q;
  // boundary when the half index moves from odd to even
  assign bit_tick = half_tick && hidx_q[0];
  assign end_hit  = half_tick && (hidx_q == hend_q - 1'b1);

  sc_half_timer #(
    .CPB_0 (CPB_0),
    .CPB_1 (CPB_1),
    .CPB_2 (CPB_2),
    .CPB_3 (CPB_3),
    .CNT_W (CNT_W)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .sel       (cfg_div),
    .run       (busy_q),
    .half_tick (half_tick)
  );

  sc_frame_shift #(
    .DATA_W (DATA_W)
  ) shift_i (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .data  (in_data),
    .odd   (cfg_odd),
    .shift (bit_tick),
    .line  (tx_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      hidx_q <= '0;
      hend_q <= HALF_W'(HALF_NORM);
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      hidx_q <= '0;
      hend_q <= cfg_early ? HALF_W'(HALF_EARLY) : HALF_W'(HALF_NORM);
    end else if (half_tick) begin
      hidx_q <= hidx_q + 1'b1;
      if (end_hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign in_ready = !busy_q;
  assign tx_done  = done_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_line); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && !tx_done)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> in_ready); // R8
  AST_EDGE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_line) |-> $past(bit_tick || accept)); // R10
  AST_END_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(hend_q)); // R9

endmodule

// File: tb/sc_char_tx_tb_top.sv
`timescale 1ns/1ps
module sc_char_tx_tb_top;

  typedef struct {
    logic [7:0] d;
    logic [1:0] sel;
    bit         odd;
    bit         early;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_odd = 1'b0;
  logic [1:0] cfg_div = 2'b00;
  logic       cfg_early = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       tx_line;
  logic       tx_done;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_busy = 1'b0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  sc_char_tx dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_odd   (cfg_odd),
    .cfg_div   (cfg_div),
    .cfg_early (cfg_early),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line),
    .tx_done   (tx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int cpb(input logic [1:0] s);
    case (s)
      2'b00:   return 32;
      2'b01:   return 64;
      2'b10:   return 372;
      default: return 256;
    endcase
  endfunction

  function automatic logic exp_bit(input exp_t e, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= 8) return e.d[idx-1];
    if (idx == 9) return (^e.d) ^ e.odd;
    return 1'b1;
  endfunction

  // driver: pushes the expected frame, offers the byte, scrambles inputs after acceptance (R9)
  task automatic send(input logic [7:0] d, input logic [1:0] s, input bit odd, input bit early);
    exp_t e;
    e.d = d; e.sel = s; e.odd = odd; e.early = early;
    @(negedge clk);
    in_data = d; cfg_div = s; cfg_odd = odd; cfg_early = early; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_data = ~d; cfg_div = ~s; cfg_odd = ~odd; cfg_early = ~early;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || mon_busy || !in_ready) @(negedge clk);
  endtask

  // monitor: detects a start bit, pops the expected frame, checks bits and end point
  initial begin : monitor
    exp_t e;
    int   s, endk, k, idx;
    bit   seen;
    forever begin
      @(negedge clk);
      if (!rst && !tx_line) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 frame without accepted byte", 1, 0);
        end else begin
          e = exp_q.pop_front();
          mon_busy = 1'b1;
          s = cpb(e.sel);
          endk = e.early ? 11 * s : (25 * s) / 2;
          k = 0;
          seen = 1'b0;
          chk(!in_ready, "R7 ready low at start", int'(in_ready), 0);
          while (!seen && k <= 13 * s) begin
            @(negedge clk);
            k++;
            if (tx_done) begin
              chk(k == endk, e.early ? "R6 early end point" : "R5 normal end point", k, endk);
              chk(in_ready, "R5 R6 ready back at end", int'(in_ready), 1);
              seen = 1'b1;
            end else if (k % s == s / 2) begin
              idx = k / s;
              chk(tx_line == exp_bit(e, idx),
                  (idx == 9) ? "R4 parity bit" : "R2 R3 bit value", int'(tx_line),
                  int'(exp_bit(e, idx)));
              chk(!in_ready, "R7 ready low in frame", int'(in_ready), 0);
            end
          end
          if (!seen) chk(1'b0, "R5 R6 end flag missing", k, endk);
          mon_busy = 1'b0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 line idle", int'(tx_line), 1);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(tx_done == 1'b1, "R1 end flag", int'(tx_done), 1);

    send(8'hA5, 2'b00, 1'b0, 1'b0);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(tx_done == 1'b1, "R8 flag held while idle", int'(tx_done), 1);
    chk(tx_line == 1'b1, "R8 line idle", int'(tx_line), 1);

    send(8'h3C, 2'b01, 1'b1, 1'b0);
    wait_idle();
    send(8'h81, 2'b11, 1'b0, 1'b1);
    wait_idle();
    send(8'h00, 2'b10, 1'b1, 1'b0);
    wait_idle();

    // back-to-back: second byte waits on the handshake (R5 R8)
    send(8'hFF, 2'b00, 1'b1, 1'b1);
    send(8'h7E, 2'b00, 1'b0, 1'b0);
    wait_idle();

    // offer while busy must be ignored (R7)
    send(8'h96, 2'b01, 1'b0, 1'b0);
    @(negedge clk);
    in_data = 8'h55; in_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 offer while busy", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(tx_line == 1'b1, "R7 no extra frame", int'(tx_line), 1);

    send(8'h01, 2'b10, 1'b0, 1'b1);
    wait_idle();
    repeat (50) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule